// File: doc/BRIEF.md
# Mode-Strapped Eight-Pin I/O Port

This block controls eight I/O pins through three memory-mapped registers: a direction register that can only be written, a data latch that can be read and written, and a pin-state register that can only be read. The pin-state register returns the synchronized levels on the pins. A strap input selects the operating mode. The mode sets the value the direction register takes at power-on. It also sets how far software controls the pins.

In single-chip mode (mode 7), pin 7 and pins 6 to 0 are under software control. In the external-bus modes (4 to 6), pins 6 to 3 always carry the four bus strobes. Each of pins 2 to 0 goes to the bus controller while that controller asserts the pin's enable. In every mode, pin 7 either outputs the system clock or acts as an input.

During software standby, a hold control chooses how the pins that carry bus-control functions behave. They either keep their last driven state or stop driving.

Top module: `mode_gpio_port`

## Requirements
- R1: After power-on reset (rst_n low), the data latch reads 0x00. The direction register is 0x00 when op_mode is 7, so pad_oe is 0x00. It is 0x80 when op_mode is not 7, so pad_oe is 0xF8 while bc_en is 0 and sw_stby is 0.
- R2: A clock edge with hw_stby high reloads the direction register with its mode-dependent power-on value.
- R3: manual_rst leaves the direction register unchanged and clears the data latch to 0x00 on the next edge. Software standby leaves the direction register unchanged.
- R4: A write with reg_wr high and reg_addr equal to 0xFEBE (direction) or 0xFF6E (data) updates that register on the next clock edge. A read of 0xFF6E returns the data latch combinationally.
- R5: A read of 0xFF5E returns pad_in through a two-flop synchronizer. A pin change becomes visible after the second rising edge.
- R6: Pin 7 drives sysclk_src when direction bit 7 is 1. When the bit is 0, pin 7 is not driven. This holds in every mode.
- R7: When op_mode is 7, pins 6 to 0 drive pad_out from the data latch, with pad_oe equal to the direction bits.
- R8: When op_mode is not 7, pins 6 to 3 are always driven and the direction register has no effect on them. pad_out[6:3] equals bc_strobe[3:0], in the order address strobe, read, high-byte write, low-byte write, from pin 6 down to pin 3.
- R9: When op_mode is not 7 and bc_en[i] is 1, pin i (i = 0 to 2) takes its enable from bc_oe[i] and its value from bc_out[i]. When bc_en[i] is 0, the pin follows its direction bit and the data latch.
- R10: While sw_stby is high, each bus-control pin behaves according to stby_hold. The bus-control pins are pins 6 to 3 and the enabled pins 2 to 0 when op_mode is not 7. With stby_hold at 1, the pin keeps the enable and value it had at the last edge before standby. With stby_hold at 0, it is not driven. The other pins are unaffected.
- R11: A write to any address other than 0xFEBE or 0xFF6E changes no register. A read of an unmapped address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| op_mode | input | 3 | Operating mode strap (4 to 7) |
| hw_stby | input | 1 | Hardware standby, reloads direction |
| manual_rst | input | 1 | Manual reset, clears data latch only |
| sw_stby | input | 1 | Software standby active |
| stby_hold | input | 1 | 1: bus-control pins hold in standby, 0: release |
| reg_addr | input | 16 | Register address (low 16 bits) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational |
| sysclk_src | input | 1 | System clock level for pin 7 |
| bc_strobe | input | 4 | Bus strobes for pins 6..3 |
| bc_en | input | 3 | Bus-controller claim for pins 2..0 |
| bc_oe | input | 3 | Bus-controller enable for pins 2..0 |
| bc_out | input | 3 | Bus-controller value for pins 2..0 |
| pad_in | input | 8 | Pin input levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output value |

## Verification
The embedded assertions check on every cycle that:
- data-latch writes land one edge later;
- the pin-state read equals the pin levels from two edges earlier;
- manual reset never disturbs the direction register;
- the strobe pins stay driven in the bus modes outside standby;
- bus-control pins stop driving in releasing standby.

The mode-dependent power-on and hardware-standby values can only be shown by the bench scenarios, because they depend on the reset strap. The same applies to the mixing of claimed and unclaimed low pins and to the value held during standby.

// File: rtl/mode_gpio_port.sv
module mode_gpio_port #(
  parameter logic [15:0] DIR_ADDR  = 16'hFEBE,
  parameter logic [15:0] DATA_ADDR = 16'hFF6E,
  parameter logic [15:0] PINS_ADDR = 16'hFF5E,
  parameter logic [7:0]  DIR_RDPAT = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  op_mode,
  input  logic        hw_stby,
  input  logic        manual_rst,
  input  logic        sw_stby,
  input  logic        stby_hold,
  input  logic [15:0] reg_addr,
  input  logic        reg_wr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        sysclk_src,
  input  logic [3:0]  bc_strobe,
  input  logic [2:0]  bc_en,
  input  logic [2:0]  bc_oe,
  input  logic [2:0]  bc_out,
  input  logic [7:0]  pad_in,
  output logic [7:0]  pad_oe,
  output logic [7:0]  pad_out
);

  logic       bus_mode;
  logic [7:0] dir_rst;
  logic [7:0] dir_q, data_q;
  logic [7:0] sync1, sync2;
  logic [7:0] live_oe, live_out, ctl_mask;
  logic [7:0] held_oe, held_out;
  logic       wr_dir, wr_data;
  logic [1:0] rd_age;

  assign bus_mode = (op_mode != 3'd7);
  assign dir_rst  = bus_mode ? 8'h80 : 8'h00;
  assign wr_dir   = reg_wr && (reg_addr == DIR_ADDR);
  assign wr_data  = reg_wr && (reg_addr == DATA_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dir_q <= dir_rst;
    else if (hw_stby) dir_q <= dir_rst;
    else if (wr_dir)  dir_q <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          data_q <= 8'h00;
    else if (manual_rst) data_q <= 8'h00;
    else if (wr_data)    data_q <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1  <= 8'h00;
      sync2  <= 8'h00;
      rd_age <= 2'd0;
    end else begin
      sync1 <= pad_in;
      sync2 <= sync1;
      if (rd_age != 2'd3) rd_age <= rd_age + 2'd1;
    end
  end

  always_comb begin
    if (reg_addr == DIR_ADDR)       reg_rdata = DIR_RDPAT;
    else if (reg_addr == DATA_ADDR) reg_rdata = data_q;
    else if (reg_addr == PINS_ADDR) reg_rdata = sync2;
    else                            reg_rdata = 8'h00;
  end

  always_comb begin
    live_oe[7]  = dir_q[7];
    live_out[7] = sysclk_src;
    if (bus_mode) begin
      live_oe[6:3]  = 4'hF;
      live_out[6:3] = bc_strobe;
    end else begin
      live_oe[6:3]  = dir_q[6:3];
      live_out[6:3] = data_q[6:3];
    end
    for (int i = 0; i < 3; i++) begin
      if (bus_mode && bc_en[i]) begin
        live_oe[i]  = bc_oe[i];
        live_out[i] = bc_out[i];
      end else begin
        live_oe[i]  = dir_q[i];
        live_out[i] = data_q[i];
      end
    end
    ctl_mask = bus_mode ? {1'b0, 4'hF, bc_en} : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_oe  <= 8'h00;
      held_out <= 8'h00;
    end else if (!sw_stby) begin
      held_oe  <= live_oe;
      held_out <= live_out;
    end
  end

  assign pad_oe  = !sw_stby ? live_oe :
                   ((live_oe & ~ctl_mask) | (stby_hold ? (held_oe & ctl_mask) : 8'h00));
  assign pad_out = !sw_stby ? live_out :
                   ((live_out & ~ctl_mask) | (stby_hold ? (held_out & ctl_mask) : 8'h00));

  // R4
  data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !manual_rst) |=> (data_q == $past(reg_wdata)));

  // R5
  pin_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_age == 2'd3 && reg_addr == PINS_ADDR) |-> (reg_rdata == $past(pad_in, 2)));

  // R3
  dir_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (manual_rst && !wr_dir && !hw_stby) |=> $stable(dir_q));

  // R8
  strobe_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_mode && !sw_stby) |-> (pad_oe[6:3] == 4'hF && pad_out[6:3] == bc_strobe));

  // R10
  stby_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_stby && !stby_hold && bus_mode) |-> (pad_oe[6:3] == 4'h0));

endmodule

// File: tb/sim_mode_gpio_port.sv
module sim_mode_gpio_port;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  op_mode = 3'd7;
  logic        hw_stby = 0, manual_rst = 0, sw_stby = 0, stby_hold = 0;
  logic [15:0] reg_addr = 16'h0000;
  logic        reg_wr = 0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic        sysclk_src = 0;
  logic [3:0]  bc_strobe = 4'h0;
  logic [2:0]  bc_en = 3'b000, bc_oe = 3'b000, bc_out = 3'b000;
  logic [7:0]  pad_in = 8'h00;
  logic [7:0]  pad_oe, pad_out;

  int vectors = 0;
  int errors = 0;

  localparam logic [15:0] A_DIR = 16'hFEBE, A_DATA = 16'hFF6E, A_PINS = 16'hFF5E;

  always #2 clk = ~clk;

  mode_gpio_port u0 (
    .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .hw_stby(hw_stby),
    .manual_rst(manual_rst), .sw_stby(sw_stby), .stby_hold(stby_hold),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sysclk_src(sysclk_src), .bc_strobe(bc_strobe), .bc_en(bc_en), .bc_oe(bc_oe),
    .bc_out(bc_out), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] m);
    @(negedge clk);
    rst_n = 0; op_mode = m; bc_en = 0; sw_stby = 0; stby_hold = 0;
    hw_stby = 0; manual_rst = 0; reg_wr = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic t_reset_values();
    logic [7:0] v;
    do_reset(3'd7);
    #1 check("R1 mode7 oe", pad_oe, 8'h00);
    rd(A_DATA, v); check("R1 data", v, 8'h00);
    do_reset(3'd4);
    #1 check("R1 mode4 oe", pad_oe, 8'hF8);
  endtask

  task automatic t_gpio_mode7();
    logic [7:0] v;
    do_reset(3'd7);
    sysclk_src = 1;
    wr(A_DIR, 8'h55);
    wr(A_DATA, 8'h3C);
    #1 check("R7 oe", pad_oe, 8'h55);
    check("R7 out", {1'b0, pad_out[6:0]}, 8'h3C);
    check("R6 clk pin", {7'd0, pad_out[7]}, 8'h01);
    rd(A_DATA, v); check("R4 data read", v, 8'h3C);
    wr(A_DIR, 8'h80);
    #1 check("R6 clk oe", pad_oe, 8'h80);
  endtask

  task automatic t_bus_pins();
    do_reset(3'd5);
    bc_strobe = 4'b1001;
    wr(A_DIR, 8'h00);
    #1 check("R8 oe ignores dir", pad_oe, 8'h78);
    check("R8 strobes", {4'd0, pad_out[6:3]}, 8'h09);
    bc_en = 3'b101; bc_oe = 3'b001; bc_out = 3'b100;
    wr(A_DIR, 8'h02);
    wr(A_DATA, 8'h07);
    #1 check("R9 oe", pad_oe, 8'h7B);
    check("R9 out", {5'd0, pad_out[2:0]}, 8'h06);
  endtask

  task automatic t_pin_read();
    logic [7:0] v;
    do_reset(3'd7);
    @(negedge clk);
    pad_in = 8'hA5;
    @(negedge clk);
    rd(A_PINS, v); check("R5 after one edge", v, 8'h00);
    @(negedge clk);
    rd(A_PINS, v); check("R5 after two edges", v, 8'hA5);
  endtask

  task automatic t_hw_stby();
    do_reset(3'd4);
    wr(A_DIR, 8'h00);
    @(negedge clk); hw_stby = 1;
    @(negedge clk); hw_stby = 0;
    #1 check("R2 mode4 reload", pad_oe, 8'hF8);
    do_reset(3'd7);
    wr(A_DIR, 8'hFF);
    @(negedge clk); hw_stby = 1;
    @(negedge clk); hw_stby = 0;
    #1 check("R2 mode7 reload", pad_oe, 8'h00);
  endtask

  task automatic t_manual_rst();
    logic [7:0] v;
    do_reset(3'd7);
    wr(A_DIR, 8'h0F);
    wr(A_DATA, 8'hFF);
    @(negedge clk); manual_rst = 1;
    @(negedge clk); manual_rst = 0;
    #1 check("R3 dir kept", pad_oe, 8'h0F);
    rd(A_DATA, v); check("R3 data cleared", v, 8'h00);
  endtask

  task automatic t_sw_stby();
    do_reset(3'd4);
    bc_strobe = 4'b1010;
    @(negedge clk);
    sw_stby = 1; stby_hold = 1;
    @(negedge clk);
    bc_strobe = 4'b0101;
    #1 check("R10 hold oe", pad_oe, 8'hF8);
    check("R10 hold out", {4'd0, pad_out[6:3]}, 8'h0A);
    stby_hold = 0;
    #1 check("R10 release oe", pad_oe, 8'h80);
    sw_stby = 0;
    #1 check("R3 dir kept across standby", pad_oe, 8'hF8);
  endtask

  task automatic t_unmapped();
    logic [7:0] v;
    do_reset(3'd7);
    wr(A_DATA, 8'h5A);
    wr(A_DIR, 8'h33);
    wr(16'h1234, 8'hFF);
    rd(A_DATA, v); check("R11 data untouched", v, 8'h5A);
    #1 check("R11 dir untouched", pad_oe, 8'h33);
    rd(16'h1234, v); check("R11 unmapped read", v, 8'h00);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    vectors++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset_values();
    t_gpio_mode7();
    t_bus_pins();
    t_pin_read();
    t_hw_stby();
    t_manual_rst();
    t_sw_stby();
    t_unmapped();
    finish_run();
  end
endmodule